// File: doc/BRIEF.md
# Triangular-Window Sample Smoother

This block smooths a stream of signed 14-bit sensor samples with a triangular window. The window is the convolution of two equal boxcars of length N = 2^M. So each accepted sample passes through two cascaded moving averages. Each average keeps a running sum and normalises that sum with an arithmetic right shift by M. The full window covers the last 2N-1 accepted samples.

The applied exponent comes from a requested tap exponent and a range-select code. Above 7 the request saturates to 7. A narrow range code then raises the exponent to a minimum. Any change on either configuration input does three things: it wipes both sample histories and both sums, it discards the samples offered around the change, and it keeps the valid strobe low until a full window of new samples has arrived.

A small controller has three states. S_FILL is entered at reset and after S_CLEAR. It counts accepted samples and moves to S_LIVE on the sample that completes 2N-1. S_LIVE passes every accepted sample to the output. S_CLEAR lasts one cycle and zeroes the histories, the sums and the fill count. A configuration change in any state moves the controller to S_CLEAR, and this transition has the highest priority. After reset the block acts as if exponent 2 with the widest range had just been applied.

Top module: `tri_win_avg`

## Requirements
- R1: During and after reset, out_vld is 0 and out_smp is 0 until the first valid result.
- R2: The boxcar length is N = 2^M. M is tap_exp (bits 3:0, unsigned), with any value above 7 taken as 7.
- R3: The range code sets a floor on M, and the narrower bit wins. If rng_sel bit 0 is set, M is at least 4. Otherwise, if bit 1 is set, M is at least 2. Otherwise there is no floor; the widest code is 3'b100. The applied M is the larger of the floor and the clamped request.
- R4: Each valid result is computed in two steps. First, s[n] is the sum of the last N accepted inputs shifted right arithmetically by M. Second, the result is the sum of the last N values of s shifted right arithmetically by M. Samples from before a flush count as zero.
- R5: When a sample is accepted in cycle k, its result and out_vld appear in cycle k+1, and out_vld lasts one cycle. If in_vld is low, out_vld is low in the next cycle.
- R6: A change of tap_exp or rng_sel from the previous cycle has three effects. The sample offered in the cycle of the change is discarded, and so is the sample in the cycle after it (S_CLEAR). Both histories and sums are zeroed. out_vld is low in the cycle after the change.
- R7: After a flush, out_vld stays low for the first 2N-2 accepted samples. It rises on the result of accepted sample 2N-1.
- R8: With M = 0 the output equals the accepted input one cycle later.
- R9: While out_vld is low, out_smp keeps its last valid value.
- R10: Out of reset the applied setting is exponent 2 with range 3'b100. If the inputs carry those values, the first sample is accepted at once and the seventh sample gives the first valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Sample strobe |
| in_smp | input | 14 | Input sample, two's complement |
| tap_exp | input | 4 | Requested tap exponent M |
| rng_sel | input | 3 | Range-select code setting the exponent floor |
| out_vld | output | 1 | Result strobe |
| out_smp | output | 14 | Filtered result, two's complement |

## Verification
The hardest case to reach is a sample offered in the same cycle as a configuration change, or in the clearing cycle that follows. If either sample leaked into a history, it would disturb results many samples later. To reach it, the bench changes the exponent while in_vld is high and keeps in_vld high through the next cycle with large opposite-signed values. It then checks that the results of the new window match a model that never saw those values. The 255-sample fill at the largest exponent is also covered. The bench drives it with a constant full-scale negative input, which takes each running sum to its most negative value.

// File: rtl/tri_avg_pkg.sv
package tri_avg_pkg;
    typedef enum logic [1:0] {
        S_FILL  = 2'd0,
        S_CLEAR = 2'd1,
        S_LIVE  = 2'd2
    } fill_state_e;
endpackage

// File: rtl/tri_avg_exp.sv
module tri_avg_exp #(
    parameter int EXP_W   = 4,
    parameter int RNG_W   = 3,
    parameter int MAX_LOG = 7,
    localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
    input  logic [EXP_W-1:0] tap_exp,
    input  logic [RNG_W-1:0] rng_sel,
    output logic [LOG_W-1:0] m_eff
);
    int floor_v;
    int req_v;

    always_comb begin
        if (rng_sel[0])      floor_v = 4;
        else if (rng_sel[1]) floor_v = 2;
        else                 floor_v = 0;
        req_v = (int'(tap_exp) > MAX_LOG) ? MAX_LOG : int'(tap_exp);
        m_eff = LOG_W'((req_v > floor_v) ? req_v : floor_v);
    end
endmodule

// File: rtl/tri_avg_box.sv
module tri_avg_box #(
    parameter int DATA_W  = 14,
    parameter int MAX_LOG = 7,
    localparam int LOG_W  = $clog2(MAX_LOG + 1),
    localparam int DEPTH  = 1 << MAX_LOG,
    localparam int SUM_W  = DATA_W + MAX_LOG
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    input  logic [LOG_W-1:0]         m,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [DATA_W-1:0] y
);
    logic signed [DATA_W-1:0] hist [DEPTH];
    logic signed [SUM_W-1:0]  sum_q;
    logic signed [SUM_W-1:0]  sum_d;
    logic [MAX_LOG-1:0]       drop_idx;
    logic signed [DATA_W-1:0] drop_v;

    always_comb begin
        drop_idx = MAX_LOG'((DEPTH - 1) >> (MAX_LOG - int'(m)));
        drop_v   = hist[drop_idx];
        sum_d    = sum_q + {{MAX_LOG{x[DATA_W-1]}}, x}
                         - {{MAX_LOG{drop_v[DATA_W-1]}}, drop_v};
        y        = DATA_W'(sum_d >>> m);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
        end else if (clr) begin
            sum_q <= '0;
            for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
        end else if (en) begin
            sum_q   <= sum_d;
            hist[0] <= x;
            for (int i = DEPTH - 1; i > 0; i--) hist[i] <= hist[i-1];
        end
    end
endmodule

// File: rtl/tri_win_avg.sv
module tri_win_avg
    import tri_avg_pkg::*;
#(
    parameter int DATA_W          = 14,
    parameter int EXP_W           = 4,
    parameter int RNG_W           = 3,
    parameter int MAX_LOG         = 7,
    parameter logic [3:0] RST_EXP = 4'd2,
    parameter logic [2:0] RST_RNG = 3'b100,
    localparam int LOG_W          = $clog2(MAX_LOG + 1),
    localparam int CNT_W          = MAX_LOG + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] in_smp,
    input  logic [EXP_W-1:0]         tap_exp,
    input  logic [RNG_W-1:0]         rng_sel,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_smp
);
    fill_state_e              state_q, state_d;
    logic [EXP_W-1:0]         exp_q;
    logic [RNG_W-1:0]         rng_q;
    logic [LOG_W-1:0]         m_cur;
    logic [CNT_W-1:0]         cnt_q;
    logic [CNT_W:0]           cnt_inc;
    logic [CNT_W:0]           need;
    logic                     cfg_chg;
    logic                     accept;
    logic                     reach;
    logic                     emit;
    logic signed [DATA_W-1:0] y1, y2;

    tri_avg_exp #(.EXP_W(EXP_W), .RNG_W(RNG_W), .MAX_LOG(MAX_LOG)) u_exp (
        .tap_exp (exp_q),
        .rng_sel (rng_q),
        .m_eff   (m_cur)
    );

    always_comb begin
        cfg_chg = (tap_exp != exp_q) || (rng_sel != rng_q);
        accept  = in_vld && !cfg_chg && (state_q != S_CLEAR);
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        need    = (CNT_W+1)'((1 << (int'(m_cur) + 1)) - 1);
        reach   = cnt_inc >= need;
        emit    = accept && ((state_q == S_LIVE) || reach);
    end

    tri_avg_box #(.DATA_W(DATA_W), .MAX_LOG(MAX_LOG)) u_box1 (
        .clk (clk), .rst_n (rst_n), .clr (state_q == S_CLEAR),
        .en  (accept), .m (m_cur), .x (in_smp), .y (y1)
    );

    tri_avg_box #(.DATA_W(DATA_W), .MAX_LOG(MAX_LOG)) u_box2 (
        .clk (clk), .rst_n (rst_n), .clr (state_q == S_CLEAR),
        .en  (accept), .m (m_cur), .x (y1), .y (y2)
    );

    always_comb begin
        state_d = state_q;
        if (cfg_chg) begin
            state_d = S_CLEAR;
        end else begin
            unique case (state_q)
                S_CLEAR: state_d = S_FILL;
                S_FILL:  if (accept && reach) state_d = S_LIVE;
                S_LIVE:  state_d = S_LIVE;
                default: state_d = S_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_FILL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= EXP_W'(RST_EXP);
            rng_q <= RNG_W'(RST_RNG);
            cnt_q <= '0;
        end else begin
            exp_q <= tap_exp;
            rng_q <= rng_sel;
            if (state_q == S_CLEAR)                 cnt_q <= '0;
            else if (state_q == S_FILL && accept)   cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_smp <= '0;
        end else begin
            out_vld <= emit;
            if (emit) out_smp <= y2;
        end
    end
endmodule

// File: rtl/tri_win_avg_chk.sv
module tri_win_avg_chk #(
    parameter int DATA_W = 14,
    parameter int EXP_W  = 4,
    parameter int RNG_W  = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_vld,
    input logic signed [DATA_W-1:0] in_smp,
    input logic [EXP_W-1:0]         tap_exp,
    input logic [RNG_W-1:0]         rng_sel,
    input logic                     out_vld,
    input logic signed [DATA_W-1:0] out_smp
);
    // R5
    vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld));

    // R6
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tap_exp != $past(tap_exp)) || (rng_sel != $past(rng_sel))) |=> !out_vld);

    // R9
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(out_smp));

    // R8
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && ($past(tap_exp) == '0) && ($past(rng_sel) == 3'b100))
        |-> (out_smp == $past(in_smp)));
endmodule

bind tri_win_avg tri_win_avg_chk #(.DATA_W(DATA_W), .EXP_W(EXP_W), .RNG_W(RNG_W)) u_chk (
    .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_smp (in_smp),
    .tap_exp (tap_exp), .rng_sel (rng_sel), .out_vld (out_vld), .out_smp (out_smp)
);

// File: tb/sim_tri_win_avg.sv
`timescale 1ns/1ps
module sim_tri_win_avg;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic signed [13:0] in_smp = '0;
    logic [3:0]        tap_exp = 4'd2;
    logic [2:0]        rng_sel = 3'b100;
    logic              out_vld;
    logic signed [13:0] out_smp;

    always #2 clk = ~clk;

    tri_win_avg u0 (
        .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_smp (in_smp),
        .tap_exp (tap_exp), .rng_sel (rng_sel), .out_vld (out_vld), .out_smp (out_smp)
    );

    int n_chk = 0;
    int n_bad = 0;
    int xh [128];
    int sh [128];
    int mcur;
    int fill;
    int last_out;
    int lfsr = 16'hACE1;

    // {tap_exp, rng_sel, pattern, count}
    localparam logic [17:0] VEC [8] = '{
        {4'd0, 3'b100, 2'd0, 9'd6},
        {4'd1, 3'b100, 2'd1, 9'd10},
        {4'd3, 3'b100, 2'd3, 9'd30},
        {4'd9, 3'b100, 2'd2, 9'd260},
        {4'd0, 3'b010, 2'd0, 9'd12},
        {4'd1, 3'b001, 2'd3, 9'd40},
        {4'd0, 3'b011, 2'd3, 9'd36},
        {4'd7, 3'b100, 2'd1, 9'd300}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int meff(input int t, input int r);
        int f;
        int q;
        f = r[0] ? 4 : (r[1] ? 2 : 0);
        q = (t > 7) ? 7 : t;
        return (q > f) ? q : f;
    endfunction

    task automatic model_clear(input int t, input int r);
        for (int i = 0; i < 128; i++) begin xh[i] = 0; sh[i] = 0; end
        fill = 0;
        mcur = meff(t, r);
    endtask

    task automatic model_step(input int x, output bit v, output int e);
        int s1;
        int s2;
        int n;
        n = 1 << mcur;
        for (int i = 127; i > 0; i--) xh[i] = xh[i-1];
        xh[0] = x;
        s1 = 0;
        for (int i = 0; i < n; i++) s1 += xh[i];
        for (int i = 127; i > 0; i--) sh[i] = sh[i-1];
        sh[0] = s1 >>> mcur;
        s2 = 0;
        for (int i = 0; i < n; i++) s2 += sh[i];
        e = s2 >>> mcur;
        fill++;
        v = (fill >= (2 * n - 1));
    endtask

    task automatic push(input int x, input string req);
        bit v;
        int e;
        @(negedge clk);
        in_vld = 1'b1;
        in_smp = 14'(x);
        model_step(x, v, e);
        @(negedge clk);
        in_vld = 1'b0;
        check(out_vld == v, {req, " R7 valid"}, int'(out_vld), int'(v));
        if (v) begin
            check(int'(out_smp) == e, {req, " R4 value"}, int'(out_smp), e);
            last_out = e;
        end else begin
            check(int'(out_smp) == last_out, {req, " R9 hold"}, int'(out_smp), last_out);
        end
    endtask

    task automatic set_cfg(input int t, input int r);
        @(negedge clk);
        tap_exp = 4'(t);
        rng_sel = 3'(r);
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0, "R6 flush quiet", int'(out_vld), 0);
        model_clear(t, r);
    endtask

    function automatic int pat(input int kind, input int i);
        case (kind)
            0: return ((i * 977) % 8000) - 4000;
            1: return (i % 2) ? 8191 : -8192;
            2: return -8192;
            default: begin
                lfsr = (lfsr & 1) ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
                return (lfsr % 16384) - 8192;
            end
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        last_out = 0;
        model_clear(2, 3'b100);
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0, "R1 reset vld", int'(out_vld), 0);
        check(out_smp == '0, "R1 reset data", int'(out_smp), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_vld == 1'b0 && out_smp == '0, "R1 after reset", int'(out_smp), 0);

        // R10: default setting, seventh sample first valid
        for (int i = 0; i < 7; i++) push(pat(0, i + 3), "R10 default");

        // R2 R3 R4 R7 R8 over table
        foreach (VEC[k]) begin
            set_cfg(int'(VEC[k][17:14]), int'(VEC[k][13:11]));
            for (int i = 0; i < int'(VEC[k][8:0]); i++)
                push(pat(int'(VEC[k][10:9]), i), $sformatf("R2 R3 vec%0d", k));
        end

        // R8 back-to-back pass-through
        set_cfg(0, 3'b100);
        @(negedge clk); in_vld = 1'b1; in_smp = 14'sd1234;
        @(negedge clk); in_smp = -14'sd777;
        check(out_vld && int'(out_smp) == 1234, "R8 pass a", int'(out_smp), 1234);
        @(negedge clk); in_vld = 1'b0;
        check(out_vld && int'(out_smp) == -777, "R8 pass b", int'(out_smp), -777);
        last_out = -777;
        @(negedge clk);
        check(out_vld == 1'b0, "R5 single pulse", int'(out_vld), 0);

        // R6 samples at change and clear cycle discarded
        @(negedge clk); tap_exp = 4'd1; in_vld = 1'b1; in_smp = 14'sd5000;
        @(negedge clk); in_smp = -14'sd5000;
        check(out_vld == 1'b0, "R6 change cycle", int'(out_vld), 0);
        @(negedge clk); in_vld = 1'b0;
        check(out_vld == 1'b0, "R6 clear cycle", int'(out_vld), 0);
        check(int'(out_smp) == -777, "R9 hold over flush", int'(out_smp), -777);
        model_clear(1, 3'b100);
        push(100, "R6 after flush");
        push(200, "R6 after flush");
        push(-300, "R6 after flush");
        push(40, "R6 after flush");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule